// File: doc/BRIEF.md
# Prefetch Burst Data Serializer

This block sits between a memory core that moves one wide word per access and a narrow data pin bus that runs at twice the command rate. All of its logic runs on a single beat clock at double the command frequency. Each flop edge therefore stands for one half of a command cycle, and the design needs only single-edge flops. Every burst is exactly four beats of 32 bits, so one core word is 128 bits.

On the write side, the block gathers four pin beats into one core word. With each beat it also gathers four per-byte mask bits, which become a 16-bit core byte-enable. It presents the finished word for exactly one cycle. The column that comes with the first beat is passed on with its two low bits forced to zero. A burst that reset cuts short produces no core write.

On the read side, the block takes one core word and sends it out as four consecutive beats, lowest 32 bits first. The four byte-lane strobes toggle together on every beat, so each data change coincides with a strobe edge. A one-entry holding register accepts the next word while a burst is still in flight. This lets consecutive bursts follow each other with no idle beat.

Top module: `burst_gearbox`

## Requirements
- R1: After reset, core_wr_valid and pin_dq_valid are 0, pin_dqs is 4'b0000 and rd_word_ready is 1.
- R2: Write beat k (k = 0..3) lands in core_wr_data bits [32k+31:32k]. core_wr_valid is high for exactly one cycle, the cycle after the edge that captures the fourth beat.
- R3: wr_beat_mask bit j of beat k set to 1 disables byte j of that beat. core_wr_be bit 4k+j equals the inverse of that mask bit.
- R4: core_wr_col carries wr_beat_col sampled with beat 0, with bits [1:0] forced to 0. The column inputs given with beats 1..3 have no effect.
- R5: A burst cut short by reset produces no core_wr_valid. The next beat after reset is taken as beat 0 of a new burst.
- R6: Beats need not be on consecutive cycles. Cycles with wr_beat_valid low are skipped and do not advance the burst.
- R7: A read word accepted at an edge (rd_word_valid and rd_word_ready both 1) shows bits [31:0] on pin_dq right after that edge. Bits [63:32], [95:64] and [127:96] follow on the next three cycles. pin_dq_valid is high for exactly those four cycles when no further word follows.
- R8: All four pin_dqs bits are always equal and invert on every beat shown. They hold steady while idle. Counting from reset, beat 0 of every burst shows 4'b1111, beat 1 shows 4'b0000, beat 2 shows 4'b1111 and beat 3 shows 4'b0000.
- R9: A word offered while a burst is in progress is held in a one-entry register and rd_word_ready drops to 0. Its beat 0 appears in the cycle right after the previous burst's beat 3, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, twice the command rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_beat_valid | input | 1 | A write beat is present this cycle |
| wr_beat_data | input | 32 | Write beat data |
| wr_beat_mask | input | 4 | Per-byte mask for the beat, 1 disables the byte |
| wr_beat_col | input | 9 | Burst column, sampled with beat 0 |
| core_wr_valid | output | 1 | One-cycle pulse, assembled core word ready |
| core_wr_data | output | 128 | Assembled core word |
| core_wr_be | output | 16 | Core byte-enable, 1 writes the byte |
| core_wr_col | output | 9 | Burst column with the low two bits cleared |
| rd_word_valid | input | 1 | A core read word is offered |
| rd_word | input | 128 | Core read word |
| rd_word_ready | output | 1 | A word offered now is accepted |
| pin_dq | output | 32 | Read beat data toward the pins |
| pin_dq_valid | output | 1 | pin_dq holds a read beat |
| pin_dqs | output | 4 | Per-byte-lane read strobes |

## Verification
The bench builds the block with its default parameters: 8-bit lanes, four lanes and a 9-bit column. These values give the full 128-bit word and 16-bit byte-enable, and they make every beat position and every strobe phase observable. The stimulus table walks four bursts that mix all-enabled, all-masked and mixed masks with columns whose low bits are set. Alternate bursts insert idle cycles between beats. Directed tests then chain two read words through the holding register, and reset is asserted halfway through a write burst.

// File: rtl/gbx_pkg.sv
package gbx_pkg;
  localparam int unsigned BURST_LEN = 4;
  localparam int unsigned BIDX_W    = $clog2(BURST_LEN);
endpackage

// File: rtl/gbx_wr_assemble.sv
module gbx_wr_assemble
  import gbx_pkg::*;
#(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned COL_W  = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        beat_valid,
  input  logic [LANES*LANE_W-1:0]     beat_data,
  input  logic [LANES-1:0]            beat_mask,
  input  logic [COL_W-1:0]            beat_col,
  output logic                        word_valid,
  output logic [LANES*LANE_W*BURST_LEN-1:0] word_data,
  output logic [LANES*BURST_LEN-1:0]  word_be,
  output logic [COL_W-1:0]            word_col
);
  localparam int unsigned BEAT_W = LANES * LANE_W;
  localparam logic [BIDX_W-1:0] LAST_IDX = BIDX_W'(BURST_LEN - 1);

  logic [BIDX_W-1:0] cnt_q, cnt_n;
  logic              valid_q, valid_n;
  logic [COL_W-1:0]  col_q;
  logic [BEAT_W-1:0] slot_d [BURST_LEN];
  logic [LANES-1:0]  slot_m [BURST_LEN];

  always_comb begin
    cnt_n   = cnt_q;
    valid_n = 1'b0;
    if (beat_valid) begin
      cnt_n   = cnt_q + 1'b1;
      valid_n = (cnt_q == LAST_IDX);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      valid_q <= valid_n;
    end
  end

  always_ff @(posedge clk) begin
    if (beat_valid && cnt_q == '0) col_q <= beat_col;
  end

  for (genvar k = 0; k < BURST_LEN; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (beat_valid && cnt_q == BIDX_W'(k)) begin
        slot_d[k] <= beat_data;
        slot_m[k] <= beat_mask;
      end
    end
    assign word_data[k*BEAT_W +: BEAT_W] = slot_d[k];
    assign word_be[k*LANES +: LANES]     = ~slot_m[k];
  end

  assign word_valid = valid_q;
  assign word_col   = {col_q[COL_W-1:2], col_q[1:0] & 2'b00};

  AST_WR_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid); // R2
  AST_WR_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(beat_valid)); // R6
endmodule

// File: rtl/gbx_rd_skid.sv
module gbx_rd_skid #(
  parameter int unsigned WORD_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              in_ready,
  input  logic              can_load,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word
);
  logic              full_q, full_n;
  logic [WORD_W-1:0] hold_q;
  logic              capture;

  assign capture = !full_q && in_valid && !can_load;

  always_comb begin
    if (full_q) full_n = !can_load;
    else        full_n = capture;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_n;
  end

  always_ff @(posedge clk) begin
    if (capture) hold_q <= in_word;
  end

  assign in_ready  = !full_q;
  assign out_valid = full_q || in_valid;
  assign out_word  = full_q ? hold_q : in_word;

  AST_SKID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    full_q && !can_load |=> full_q && $stable(hold_q)); // R9
endmodule

// File: rtl/gbx_rd_shift.sv
module gbx_rd_shift
  import gbx_pkg::*;
#(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 src_valid,
  input  logic [LANES*LANE_W*BURST_LEN-1:0]    src_word,
  output logic                                 can_load,
  output logic [LANES*LANE_W-1:0]              dq,
  output logic                                 dq_valid,
  output logic [LANES-1:0]                     dqs
);
  localparam int unsigned BEAT_W = LANES * LANE_W;
  localparam int unsigned WORD_W = BEAT_W * BURST_LEN;
  localparam logic [BIDX_W-1:0] LAST_IDX = BIDX_W'(BURST_LEN - 1);

  logic              busy_q, busy_n;
  logic [BIDX_W-1:0] bidx_q, bidx_n;
  logic              strobe_q, strobe_n;
  logic [WORD_W-1:0] sh_q;
  logic              last, load;

  assign last     = busy_q && (bidx_q == LAST_IDX);
  assign can_load = !busy_q || last;
  assign load     = can_load && src_valid;

  always_comb begin
    busy_n = busy_q;
    bidx_n = bidx_q;
    if (load) begin
      busy_n = 1'b1;
      bidx_n = '0;
    end else if (last) begin
      busy_n = 1'b0;
    end else if (busy_q) begin
      bidx_n = bidx_q + 1'b1;
    end
    strobe_n = busy_n ? !strobe_q : strobe_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      bidx_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      busy_q   <= busy_n;
      bidx_q   <= bidx_n;
      strobe_q <= strobe_n;
    end
  end

  always_ff @(posedge clk) begin
    if (load) sh_q <= src_word;
  end

  assign dq       = sh_q[bidx_q*BEAT_W +: BEAT_W];
  assign dq_valid = busy_q;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign dqs[j] = strobe_q;
  end

  AST_DQS_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_valid |-> strobe_q != $past(strobe_q)); // R8
  AST_DQS_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_valid |-> $stable(strobe_q)); // R8
  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    last && src_valid |=> dq_valid && bidx_q == '0); // R9
endmodule

// File: rtl/burst_gearbox.sv
module burst_gearbox
  import gbx_pkg::*;
#(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned COL_W  = 9
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_beat_valid,
  input  logic [LANES*LANE_W-1:0]              wr_beat_data,
  input  logic [LANES-1:0]                     wr_beat_mask,
  input  logic [COL_W-1:0]                     wr_beat_col,
  output logic                                 core_wr_valid,
  output logic [LANES*LANE_W*BURST_LEN-1:0]    core_wr_data,
  output logic [LANES*BURST_LEN-1:0]           core_wr_be,
  output logic [COL_W-1:0]                     core_wr_col,
  input  logic                                 rd_word_valid,
  input  logic [LANES*LANE_W*BURST_LEN-1:0]    rd_word,
  output logic                                 rd_word_ready,
  output logic [LANES*LANE_W-1:0]              pin_dq,
  output logic                                 pin_dq_valid,
  output logic [LANES-1:0]                     pin_dqs
);
  localparam int unsigned WORD_W = LANES * LANE_W * BURST_LEN;

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic              can_load;
  logic              src_valid;
  logic [WORD_W-1:0] src_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  gbx_wr_assemble #(.LANE_W(LANE_W), .LANES(LANES), .COL_W(COL_W)) u_wr (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .beat_valid (wr_beat_valid),
    .beat_data  (wr_beat_data),
    .beat_mask  (wr_beat_mask),
    .beat_col   (wr_beat_col),
    .word_valid (core_wr_valid),
    .word_data  (core_wr_data),
    .word_be    (core_wr_be),
    .word_col   (core_wr_col)
  );

  gbx_rd_skid #(.WORD_W(WORD_W)) u_skid (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .in_valid  (rd_word_valid),
    .in_word   (rd_word),
    .in_ready  (rd_word_ready),
    .can_load  (can_load),
    .out_valid (src_valid),
    .out_word  (src_word)
  );

  gbx_rd_shift #(.LANE_W(LANE_W), .LANES(LANES)) u_shift (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .src_valid (src_valid),
    .src_word  (src_word),
    .can_load  (can_load),
    .dq        (pin_dq),
    .dq_valid  (pin_dq_valid),
    .dqs       (pin_dqs)
  );

  AST_READY_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_core_n)
    !rd_word_ready |-> pin_dq_valid); // R9
endmodule

// File: tb/tb_burst_gearbox.sv
module tb_burst_gearbox;
  logic         clk;
  logic         rst_n;
  logic         wr_beat_valid;
  logic [31:0]  wr_beat_data;
  logic [3:0]   wr_beat_mask;
  logic [8:0]   wr_beat_col;
  logic         core_wr_valid;
  logic [127:0] core_wr_data;
  logic [15:0]  core_wr_be;
  logic [8:0]   core_wr_col;
  logic         rd_word_valid;
  logic [127:0] rd_word;
  logic         rd_word_ready;
  logic [31:0]  pin_dq;
  logic         pin_dq_valid;
  logic [3:0]   pin_dqs;

  int checks = 0;
  int errors = 0;

  burst_gearbox dut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  localparam int NV = 4;
  localparam logic [127:0] V_WORD [NV] = '{
    128'h33332222_11110000_DDDDCCCC_BBBBAAAA,
    128'hFEEDFACE_CAFEBABE_DEADBEEF_01234567,
    128'h80000001_7FFFFFFE_00000000_FFFFFFFF,
    128'h0F0F0F0F_F0F0F0F0_55555555_AAAAAAAA };
  localparam logic [15:0] V_MASK [NV] = '{16'h0000, 16'hFFFF, 16'hA5C3, 16'h0F01};
  localparam logic [8:0]  V_COL  [NV] = '{9'h1FF, 9'h0A6, 9'h003, 9'h154};

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_burst(input logic [127:0] w, input logic [15:0] m,
                             input logic [8:0] c, input bit gap);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      wr_beat_valid = 1'b1;
      wr_beat_data  = w[k*32 +: 32];
      wr_beat_mask  = m[k*4 +: 4];
      wr_beat_col   = (k == 0) ? c : ~c;
      if (gap && k < 3) begin
        @(negedge clk);
        wr_beat_valid = 1'b0;
        wr_beat_col   = 9'h1FF;
        chk("R6 no write mid-burst", {127'd0, core_wr_valid}, 128'd0);
      end
    end
    @(negedge clk);
    wr_beat_valid = 1'b0;
    chk("R2 write pulse", {127'd0, core_wr_valid}, 128'd1);
    chk("R2 write word", core_wr_data, w);
    chk("R3 byte enable", {112'd0, core_wr_be}, {112'd0, ~m});
    chk("R4 column", {119'd0, core_wr_col}, {119'd0, c & 9'h1FC});
    @(negedge clk);
    chk("R2 pulse one cycle", {127'd0, core_wr_valid}, 128'd0);
  endtask

  task automatic check_beats(input logic [127:0] w, input string req);
    for (int k = 0; k < 4; k++) begin
      chk(req, {127'd0, pin_dq_valid}, 128'd1);
      chk(req, {96'd0, pin_dq}, {96'd0, w[k*32 +: 32]});
      chk("R8 strobe phase", {124'd0, pin_dqs}, {124'd0, (k % 2 == 0) ? 4'hF : 4'h0});
      @(negedge clk);
    end
  endtask

  task automatic read_burst(input logic [127:0] w);
    @(negedge clk);
    chk("R7 ready before load", {127'd0, rd_word_ready}, 128'd1);
    rd_word_valid = 1'b1;
    rd_word       = w;
    @(negedge clk);
    rd_word_valid = 1'b0;
    rd_word       = '0;
    check_beats(w, "R7 read beat");
    chk("R7 idle after burst", {127'd0, pin_dq_valid}, 128'd0);
    chk("R8 strobe held idle", {124'd0, pin_dqs}, 128'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    wr_beat_valid = 1'b0;
    wr_beat_data  = '0;
    wr_beat_mask  = '0;
    wr_beat_col   = '0;
    rd_word_valid = 1'b0;
    rd_word       = '0;
    rst_n         = 1'b0;
    do_reset();

    chk("R1 no write", {127'd0, core_wr_valid}, 128'd0);
    chk("R1 no read beat", {127'd0, pin_dq_valid}, 128'd0);
    chk("R1 strobes low", {124'd0, pin_dqs}, 128'd0);
    chk("R1 ready", {127'd0, rd_word_ready}, 128'd1);

    for (int i = 0; i < NV; i++) begin
      write_burst(V_WORD[i], V_MASK[i], V_COL[i], (i % 2) == 1);
      read_burst(V_WORD[i]);
    end

    // R9: second word offered during first burst
    @(negedge clk);
    rd_word_valid = 1'b1;
    rd_word       = V_WORD[1];
    @(negedge clk);
    rd_word       = V_WORD[2];
    @(negedge clk);
    rd_word_valid = 1'b0;
    rd_word       = '0;
    chk("R9 ready low while held", {127'd0, rd_word_ready}, 128'd0);
    chk("R9 first beat1", {96'd0, pin_dq}, {96'd0, V_WORD[1][63:32]});
    @(negedge clk);
    @(negedge clk);
    chk("R9 first beat3", {96'd0, pin_dq}, {96'd0, V_WORD[1][127:96]});
    @(negedge clk);
    check_beats(V_WORD[2], "R9 no-gap beat");
    chk("R9 idle after chain", {127'd0, pin_dq_valid}, 128'd0);
    chk("R9 ready again", {127'd0, rd_word_ready}, 128'd1);

    // R5: reset during partial write burst
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      wr_beat_valid = 1'b1;
      wr_beat_data  = 32'hBAD0_0000 + k;
      wr_beat_mask  = 4'hF;
      wr_beat_col   = 9'h111;
    end
    @(negedge clk);
    wr_beat_valid = 1'b0;
    rst_n = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R5 no write on abort", {127'd0, core_wr_valid}, 128'd0);
    end
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R5 no write after reset", {127'd0, core_wr_valid}, 128'd0);
    end
    write_burst(V_WORD[3], V_MASK[2], 9'h0ED, 1'b0);
    read_burst(V_WORD[0]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule